// File: doc/BRIEF.md
# Extended-Data-Out Page-Mode Output Stage

This block models how data leaves an extended-data-out DRAM while a row is held open. All strobes are active low and are sampled on a system clock. An edge on a strobe is found by comparing its sample with the sample from the cycle before. When the row strobe falls with chip select asserted, the block latches a row. Each later falling edge of the column strobe latches a column and reads that word from a small internal cell array onto the data output.

The output is not released when the column strobe rises. The word stays on the output while the controller sets up the next column. A new column access can therefore overlap the previous one, so page-mode reads can run at one word every two clocks with no gap on the output. Three things end the output: a new column fall, which replaces the word; a rising row strobe; or any change on chip select, output enable or write enable. A column fall with write enable low stores the input word and keeps the output off. The off state of the output is shown by `dout_oe` low, with `dout` forced to zero.

Top module: `edo_out_stage`

## Requirements
- R1: After reset `dout_oe` is 0 and `dout` is 0.
- R2: A read is a column-strobe fall sampled while a row is open, with `cs_n`=0, `we_n`=1 and `oe_n`=0, and with none of `cs_n`/`oe_n`/`we_n` changed from the previous sample. One clock after a read, `dout_oe` is 1 and `dout` holds the word stored at address {row, addr[COL_W-1:0]}.
- R3: While the column strobe is high and the row strobe stays low, with the controls unchanged, `dout_oe` stays 1 and `dout` stays unchanged.
- R4: A later read in the same open row replaces `dout` with the newly addressed word. There is no cycle between the two words with the output off.
- R5: One clock after the row strobe rises, `dout_oe` is 0 and the row is closed.
- R6: One clock after any change on `cs_n`, `oe_n` or `we_n`, `dout_oe` is 0. The output stays off until the next read.
- R7: A column-strobe fall while `ras_n` is high, or while no row is open, reads nothing, writes nothing and leaves the output off.
- R8: A column-strobe fall with `we_n`=0 in an open row stores `din` at {row, column}. It leaves `dout_oe` at 0.
- R9: A row-strobe fall with `cs_n`=0 latches the row from addr[ROW_W-1:0]. Later accesses use that row until the row strobe rises.
- R10: If the column strobe alternates low and high on every clock, a new word appears every two clocks and `dout_oe` stays 1 throughout.
- R11: A read with `oe_n`=1 leaves `dout_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when the output is off |
| dout_oe | output | 1 | Output driven (1) or released (0) |

## Verification
A wrong latched row, or a wrong cell, shows at the ports as a wrong word on `dout` one clock after the column fall that reads it. Each row is therefore filled with an address-dependent pattern, so that any wrong mapping gives a mismatch. A broken hold or release path shows one clock after the column strobe rises, or one clock after the row strobe or a control signal changes: the output enable or the word is wrong at that point. A write that was wrongly accepted or dropped does not show until the same cell is read back, so every ignored or rejected write is followed by a read of that cell.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int NUM_STB = 5;
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_CS  = 2;
    localparam int STB_OE  = 3;
    localparam int STB_WE  = 4;
endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    // one detector per strobe, each comparing against its last sample
    for (genvar i = 0; i < N; i++) begin : g_det
        assign fall[i] = prev_q[i] & ~raw[i];
        assign rise[i] = ~prev_q[i] & raw[i];
    end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
    parameter int DW = 8,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[idx];
endmodule

// File: rtl/edo_out_stage.sv
module edo_out_stage #(
    parameter int DW    = 8,
    parameter int ROW_W = 3,
    parameter int COL_W = 3,
    parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    import edo_pkg::*;

    localparam int IW = ROW_W + COL_W;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             row_open;
        logic [DW-1:0]    data;
        logic             en;
    } stage_t;

    stage_t st_d, st_q;

    logic [NUM_STB-1:0] raw, fall, rise;
    logic               ctl_chg, access, wr_en;
    logic [IW-1:0]      idx;
    logic [DW-1:0]      rd_data;

    always_comb begin
        raw          = '1;
        raw[STB_RAS] = ras_n;
        raw[STB_CAS] = cas_n;
        raw[STB_CS]  = cs_n;
        raw[STB_OE]  = oe_n;
        raw[STB_WE]  = we_n;
    end

    edo_strobe_edge #(.N(NUM_STB)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .fall (fall),
        .rise (rise)
    );

    assign ctl_chg = fall[STB_CS] | rise[STB_CS] | fall[STB_OE] | rise[STB_OE]
                   | fall[STB_WE] | rise[STB_WE];
    assign access  = fall[STB_CAS] & st_q.row_open & ~ras_n & ~cs_n;
    assign wr_en   = access & ~we_n;
    assign idx     = {st_q.row, addr[COL_W-1:0]};

    edo_cell_array #(.DW(DW), .IW(IW)) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (idx),
        .wr_data(din),
        .rd_data(rd_data)
    );

    always_comb begin
        st_d = st_q;
        if (rise[STB_RAS]) begin
            st_d.row_open = 1'b0;
            st_d.en       = 1'b0;
        end else if (fall[STB_RAS] && !cs_n) begin
            st_d.row      = addr[ROW_W-1:0];
            st_d.row_open = 1'b1;
        end
        if (ctl_chg) st_d.en = 1'b0;
        if (access) begin
            if (!we_n) begin
                st_d.en = 1'b0;
            end else if (!ctl_chg) begin
                st_d.data = rd_data;
                st_d.en   = ~oe_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.en ? st_q.data : '0;
    assign dout_oe = st_q.en;
endmodule

// File: rtl/edo_out_stage_chk.sv
module edo_out_stage_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [DW-1:0] dout,
    input logic          dout_oe
);
    // R5
    ras_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> !dout_oe);

    // R6
    ctl_change_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cs_n) || !$stable(oe_n) || !$stable(we_n)) |=> !dout_oe);

    // R3
    hold_after_cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && cas_n && !ras_n && $stable(cs_n) && $stable(oe_n) && $stable(we_n))
        |=> (dout_oe && $stable(dout)));

    // R7
    no_row_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !dout_oe) |=> !dout_oe);

    // R8
    write_keeps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !dout_oe) |=> !dout_oe);

    // R2
    enable_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> ($past(!cas_n) && $past(!oe_n) && $past(we_n)));
endmodule

bind edo_out_stage edo_out_stage_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .dout   (dout),
    .dout_oe(dout_oe)
);

// File: tb/edo_out_stage_tb.sv
module edo_out_stage_tb;
    localparam int DW = 8;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, cs_n = 1'b0, oe_n = 1'b0, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    edo_out_stage u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .cs_n(cs_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [DW-1:0] pat(input int r, input int c);
        return DW'((r * 8 + c) * 37 + 5);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic open_row(input int r);
        addr = AW'(r); ras_n = 1'b0; step();
    endtask

    task automatic close_row();
        ras_n = 1'b1; step();
    endtask

    task automatic write_word(input int c, input logic [DW-1:0] d);
        we_n = 1'b0; step();
        addr = AW'(c); din = d; cas_n = 1'b0; step();
        chk("R8 write keeps output off", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
        cas_n = 1'b1; step();
        we_n = 1'b1; step();
    endtask

    // column fall only; output checked one clock later
    task automatic read_fall(input int c);
        addr = AW'(c); cas_n = 1'b0; step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        chk("R1 reset state", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
        rst_n = 1'b1; step(); step();
        chk("R1 after release", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
    endtask

    task automatic t_fill();
        for (int r = 2; r <= 5; r += 3) begin
            open_row(r);
            for (int c = 0; c < 8; c++) write_word(c, pat(r, c));
            close_row();
        end
    endtask

    task automatic t_page_read();
        open_row(2);
        read_fall(3);
        chk("R2 read row2 col3", {dout_oe, dout}, {1'b1, pat(2, 3)});
        cas_n = 1'b1; step();
        chk("R3 hold after cas rise", {dout_oe, dout}, {1'b1, pat(2, 3)});
        addr = 3'd6; step();
        chk("R3 hold while next column set up", {dout_oe, dout}, {1'b1, pat(2, 3)});
        cas_n = 1'b0; step();
        chk("R4 replaced by col6", {dout_oe, dout}, {1'b1, pat(2, 6)});
        cas_n = 1'b1; step();
        close_row();
        open_row(5);
        read_fall(6);
        chk("R9 row5 latched", {dout_oe, dout}, {1'b1, pat(5, 6)});
        cas_n = 1'b1; step();
        close_row();
    endtask

    task automatic t_back_to_back();
        open_row(5);
        for (int c = 0; c < 8; c++) begin
            read_fall(c);
            chk("R10 word on fall", {dout_oe, dout}, {1'b1, pat(5, c)});
            cas_n = 1'b1; step();
            chk("R10 word held on rise", {dout_oe, dout}, {1'b1, pat(5, c)});
        end
        close_row();
        chk("R5 ras rise releases output", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
    endtask

    task automatic t_no_row();
        read_fall(4);
        chk("R7 column with ras high", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
        cas_n = 1'b1; step();
        we_n = 1'b0; step();
        addr = 3'd1; din = 8'h3C; cas_n = 1'b0; step();
        cas_n = 1'b1; step();
        we_n = 1'b1; step();
        open_row(2);
        read_fall(1);
        chk("R7 write with ras high ignored", {dout_oe, dout}, {1'b1, pat(2, 1)});
        cas_n = 1'b1; step();
        close_row();
    endtask

    task automatic t_ctl_change();
        open_row(2);
        read_fall(0);
        cas_n = 1'b1; step();
        oe_n = 1'b1; step();
        chk("R6 oe change releases", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
        read_fall(5);
        chk("R11 read with oe high stays off", {dout_oe, dout}, {1'b0, {DW{1'b0}}});
        cas_n = 1'b1; oe_n = 1'b0; step();
        chk("R6 stays off after oe returns", dout_oe, 1'b0);
        read_fall(5);
        chk("R2 read row2 col5", {dout_oe, dout}, {1'b1, pat(2, 5)});
        cas_n = 1'b1; step();
        cs_n = 1'b1; step();
        chk("R6 cs change releases", dout_oe, 1'b0);
        cs_n = 1'b0; step();
        read_fall(7);
        chk("R2 read row2 col7", {dout_oe, dout}, {1'b1, pat(2, 7)});
        cas_n = 1'b1; step();
        we_n = 1'b0; step();
        chk("R6 we change releases", dout_oe, 1'b0);
        we_n = 1'b1; step();
        close_row();
    endtask

    task automatic t_overwrite();
        open_row(5);
        write_word(2, 8'hE1);
        read_fall(2);
        chk("R8 written word read back", {dout_oe, dout}, {1'b1, 8'hE1});
        cas_n = 1'b1; step();
        close_row();
    endtask

    initial begin
        t_reset();
        t_fill();
        t_page_read();
        t_back_to_back();
        t_no_row();
        t_ctl_change();
        t_overwrite();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule